// File: doc/BRIEF.md
# Tick-Driven Compare Timer with Watchdog Channel

This block keeps a free-running up-counter that advances by one whenever its tick enable is high. The counter is compared against a bank of compare registers. A compare channel sets a sticky status flag on the tick that makes the counter equal to its compare value. Each flag can raise its own interrupt line when the channel's enable bit is set. All registers sit behind a small synchronous write port and a read port with one register stage.

The highest compare channel can also serve as a watchdog. Software arms it by writing a one to the arm register. After that, a match on that channel produces a one-cycle reset request as well as its normal status flag. Only the block reset can disarm the watchdog. The tick must come from an external fixed-rate source; this block neither generates nor divides it.

Register addresses on `addr_i`:
- 0 to 3: compare values.
- 4: counter.
- 5: status, write one to clear.
- 6: interrupt enables.
- 7: watchdog arm, bit 0.

Reads of any other address return zero.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the counter, all compare values, status flags, interrupt enables and the arm bit are zero. On each clock with `tick_i` high and no counter write, the counter advances by one. With `tick_i` low and no counter write, the counter holds its value.
- R2: On a tick, the counter wraps from 0xFFFFFFFF to 0. A compare value of 0 matches on that wrapping tick.
- R3: A write to address 4 loads `wdata_i` into the counter and overrides a tick in the same cycle. No match is evaluated in that cycle, even if the loaded value equals a compare value.
- R4: When a tick moves the counter to a value exactly equal to compare register i, status bit i is set in the same clock edge that updates the counter.
- R5: Status bits are sticky. Writing address 5 clears each status bit i whose `wdata_i[i]` is 1, and writing 0 to a bit leaves it unchanged. If a match and a clear of the same bit happen in the same cycle, the bit ends set.
- R6: `irq_o[i]` is high exactly while status bit i and enable bit i (address 6, bit i) are both set.
- R7: Writing address 7 with bit 0 equal to 1 sets the arm bit. Writing 0 does not clear it; only reset clears it. The arm bit reads back on bit 0 of address 7.
- R8: While the watchdog is armed, a channel 3 match drives `wdog_rst_o` high for the one cycle in which status bit 3 is first set. While the watchdog is not armed, `wdog_rst_o` stays low.
- R9: `rdata_o` is registered. After each clock edge it holds the value that the register selected by `addr_i` had before that edge. Status is returned on bits 3:0, enables on bits 3:0, and the arm bit on bit 0. Unmapped addresses read zero.
- R10: A write to address 0 to 3 replaces that compare value, which then reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| status_o | output | 4 | Sticky match flags |
| irq_o | output | 4 | Per-channel interrupt lines |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The counter, the status flags, the watchdog request and the read data all change at the same clock edge as the tick or write that causes them. The interrupt lines follow the status and enable flops with no extra stage. The bench drives every stimulus on a falling edge and lets exactly one rising edge pass. At the next falling edge it compares the outputs against a reference model that it has advanced by that same single edge. On top of these per-cycle comparisons, directed checks cover the corner cases: wrap, a load overriding a tick, a clear racing a match, the arm bit refusing to clear, and the watchdog pulse lasting one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 4;
  typedef logic [ADDR_W-1:0] tmr_addr_t;

  localparam tmr_addr_t A_CNT  = 4'd4;
  localparam tmr_addr_t A_STAT = 4'd5;
  localparam tmr_addr_t A_IEN  = 4'd6;
  localparam tmr_addr_t A_ARM  = 4'd7;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] next_o,
  output logic         adv_o
);
  logic [W-1:0] cnt_q;

  assign next_o = cnt_q + W'(1);
  assign adv_o  = tick_i & ~load_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= next_o;
  end

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '1) |=> cnt_q == '0); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         match_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ien_we_i,
  input  logic         ien_d_i,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] next_cnt_i,
  output logic [W-1:0] match_o,
  output logic         status_o,
  output logic         ien_o,
  output logic         hit_o,
  output logic         irq_o
);
  logic [W-1:0] match_q;
  logic         status_q, ien_q;

  // compare against the value the counter is about to take
  assign hit_o    = adv_i && (next_cnt_i == match_q);
  assign match_o  = match_q;
  assign status_o = status_q;
  assign ien_o    = ien_q;
  assign irq_o    = status_q & ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= '0;
      status_q <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (match_we_i) match_q <= wdata_i;
      if (ien_we_i)   ien_q   <= ien_d_i;
      status_q <= (status_q & ~clr_i) | hit_o;
    end
  end

  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> status_q); // R4
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr_i) |=> status_q); // R5
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tmr_addr_t           addr_i,
  input  logic [W-1:0]        cnt_i,
  input  logic [N-1:0][W-1:0] match_i,
  input  logic [N-1:0]        status_i,
  input  logic [N-1:0]        ien_i,
  input  logic                arm_i,
  output logic [W-1:0]        rdata_o
);
  logic [W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (addr_i == A_CNT)       rd_d = cnt_i;
    else if (addr_i == A_STAT) rd_d = {{(W-N){1'b0}}, status_i};
    else if (addr_i == A_IEN)  rd_d = {{(W-N){1'b0}}, ien_i};
    else if (addr_i == A_ARM)  rd_d = {{(W-1){1'b0}}, arm_i};
    for (int i = 0; i < int'(N); i++)
      if (addr_i == tmr_addr_t'(i)) rd_d = match_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              wdog_rst_o
);
  localparam int unsigned WDOG_CH = NUM_CH - 1;

  logic [CNT_W-1:0]              cnt, next_cnt;
  logic                          adv, cnt_load, ien_we;
  logic [NUM_CH-1:0]             stat, ien, hit, irq, stat_clr;
  logic [NUM_CH-1:0][CNT_W-1:0]  match;
  logic                          arm_q, wdog_q;

  assign cnt_load = wr_en_i && (addr_i == A_CNT);
  assign ien_we   = wr_en_i && (addr_i == A_IEN);
  assign stat_clr = (wr_en_i && addr_i == A_STAT) ? wdata_i[NUM_CH-1:0] : '0;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .cnt_o      (cnt),
    .next_o     (next_cnt),
    .adv_o      (adv)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .match_we_i (wr_en_i && (addr_i == tmr_addr_t'(i))),
      .wdata_i    (wdata_i),
      .ien_we_i   (ien_we),
      .ien_d_i    (wdata_i[i]),
      .clr_i      (stat_clr[i]),
      .adv_i      (adv),
      .next_cnt_i (next_cnt),
      .match_o    (match[i]),
      .status_o   (stat[i]),
      .ien_o      (ien[i]),
      .hit_o      (hit[i]),
      .irq_o      (irq[i])
    );
  end

  // arm bit only sets; reset is the sole way out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      wdog_q <= 1'b0;
    end else begin
      arm_q  <= arm_q | (wr_en_i && addr_i == A_ARM && wdata_i[0]);
      wdog_q <= hit[WDOG_CH] & arm_q;
    end
  end

  tmr_rdmux #(.W(CNT_W), .N(NUM_CH)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .cnt_i    (cnt),
    .match_i  (match),
    .status_i (stat),
    .ien_i    (ien),
    .arm_i    (arm_q),
    .rdata_o  (rdata_o)
  );

  assign status_o   = stat;
  assign irq_o      = irq;
  assign wdog_rst_o = wdog_q;

  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |=> arm_q); // R7
  AST_WDOG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q |=> !wdog_rst_o); // R8
  AST_WDOG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> stat[WDOG_CH]); // R8
endmodule

// File: tb/sim_tick_match_timer.sv
module sim_tick_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  status, irq;
  logic        wdog;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_cnt, m_rd;
  logic [31:0] m_match [4];
  logic [3:0]  m_stat, m_ien;
  logic        m_arm, m_wdog;

  always #5 clk = ~clk;

  tick_match_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .status_o(status), .irq_o(irq),
    .wdog_rst_o(wdog)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a < 4)  return m_match[a[1:0]];
    if (a == 4) return m_cnt;
    if (a == 5) return {28'd0, m_stat};
    if (a == 6) return {28'd0, m_ien};
    if (a == 7) return {31'd0, m_arm};
    return '0;
  endfunction

  // one clock: drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic step(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
    logic [3:0] hit, clr;
    logic ld;
    tick = t; wr = w; addr = a; wdata = d;
    @(posedge clk);
    ld  = w && a == 4;
    clr = (w && a == 5) ? d[3:0] : 4'd0;
    for (int i = 0; i < 4; i++) hit[i] = t && !ld && ((m_cnt + 32'd1) == m_match[i]);
    m_rd   = model_read(a);
    m_wdog = hit[3] && m_arm;
    m_stat = (m_stat & ~clr) | hit;
    if (ld) m_cnt = d; else if (t) m_cnt = m_cnt + 32'd1;
    if (w && a < 4) m_match[a[1:0]] = d;
    if (w && a == 6) m_ien = d[3:0];
    if (w && a == 7) m_arm = m_arm | d[0];
    @(negedge clk);
    tick = 0; wr = 0;
    check("R4 status", {28'd0, status}, {28'd0, m_stat});
    check("R6 irq", {28'd0, irq}, {28'd0, m_stat & m_ien});
    check("R8 wdog", {31'd0, wdog}, {31'd0, m_wdog});
    check("R9 rdata", rdata, m_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_stat = 0; m_ien = 0; m_arm = 0; m_rd = 0; m_wdog = 0;
    for (int i = 0; i < 4; i++) m_match[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", {28'd0, status}, 32'd0);
    check("R1 reset irq", {28'd0, irq}, 32'd0);
    check("R1 reset wdog", {31'd0, wdog}, 32'd0);
    step(0, 0, 4, 0);
    check("R1 reset counter", rdata, 32'd0);

    // basic matches
    step(0, 1, 0, 3); step(0, 1, 1, 5); step(0, 1, 2, 5); step(0, 1, 3, 40);
    step(0, 1, 6, 32'h5);
    step(0, 0, 1, 0);
    check("R10 match readback", rdata, 32'd5);
    for (int k = 0; k < 8; k++) step(1, 0, 4'(k), 0);
    check("R4 flags after 8 ticks", {28'd0, status}, 32'h7);
    check("R6 irq gated", {28'd0, irq}, 32'h5);
    for (int k = 0; k < 3; k++) step(0, 0, 4, 0);
    check("R1 hold without tick", rdata, 32'd8);

    // write-one-to-clear
    step(0, 1, 5, 32'h1);
    check("R5 clear bit0", {28'd0, status}, 32'h6);
    step(0, 1, 5, 32'h0);
    check("R5 zero write no effect", {28'd0, status}, 32'h6);
    step(0, 1, 4, 9); step(0, 1, 0, 10);
    step(1, 1, 5, 32'h1);
    check("R5 set wins over clear", {31'd0, status[0]}, 32'd1);

    // load overrides tick, no match on load
    step(0, 1, 2, 32'h20); step(0, 1, 5, 32'hF);
    step(1, 1, 4, 32'h20);
    check("R3 no match on load", {31'd0, status[2]}, 32'd0);
    step(0, 0, 4, 0);
    check("R3 load value", rdata, 32'h20);

    // wrap
    step(0, 1, 1, 0); step(0, 1, 4, 32'hFFFF_FFFF);
    step(1, 0, 4, 0);
    check("R2 match at wrap", {31'd0, status[1]}, 32'd1);
    step(0, 0, 4, 0);
    check("R2 wrapped count", rdata, 32'd0);

    // watchdog
    step(0, 1, 5, 32'hF); step(0, 1, 3, 16); step(0, 1, 4, 15);
    step(1, 0, 0, 0);
    check("R8 unarmed no request", {31'd0, wdog}, 32'd0);
    step(0, 1, 7, 1); step(0, 1, 7, 0);
    step(0, 0, 7, 0);
    check("R7 arm survives zero write", rdata, 32'd1);
    step(0, 1, 4, 15);
    step(1, 0, 0, 0);
    check("R8 armed request", {31'd0, wdog}, 32'd1);
    step(1, 0, 0, 0);
    check("R8 one-cycle pulse", {31'd0, wdog}, 32'd0);

    // sweep channels, offsets and enable patterns
    for (int ch = 0; ch < 4; ch++)
      for (int off = 1; off <= 6; off++) begin
        step(0, 1, 5, 32'hF);
        step(0, 1, 4'(ch), 32'(100 + off));
        step(0, 1, 4, 100);
        for (int k = 0; k < 8; k++) step(1, 0, 4'(k % 8), 0);
      end
    for (int v = 0; v < 16; v++) begin
      step(0, 1, 6, 32'(v));
      step(0, 0, 6, 0);
      check("R6 enable readback", rdata, 32'(v));
    end
    for (int a = 8; a < 16; a++) step(0, 0, 4'(a), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule